// File: doc/BRIEF.md
# Binary Address to Prime Module Number Translator

This block maps a 23-bit unsigned binary address onto one of 67 memory modules. It returns the address modulo 67 as a 7-bit module number. A memory system with a prime number of banks uses it to pick the bank for every generated address. The block never divides. The address is split into three fields, taken from the top as 8, 8 and 7 bits. Each of the two upper fields selects an entry in a constant table. That entry holds the residue of the field's value multiplied by its real place weight. The lowest field has a range of 0..127, so one conditional subtraction of 67 reduces it. Two modulo-67 adders then merge the three partial residues.

Both tables are computed by a function while the design elaborates, so no memory file is needed. The result is registered. It appears one clock after the input strobe, together with a valid flag. When the strobe is low the registered result holds its value.

Top module: `modtr_translator`

## Requirements
- R1: While reset (rst_n low) is asserted, and after it is released, out_valid is 0 and residue is 0 until the first accepted input.
- R2: When in_valid is 1 at a rising clock edge, residue equals addr mod 67 after that edge.
- R3: out_valid after each rising edge equals the in_valid sampled at that edge.
- R4: When in_valid is 0 at an edge, residue keeps its previous value, whatever addr carries.
- R5: residue is always below 67.
- R6: The corner addresses give these residues: 0 gives 0, 66 gives 66, 67 gives 0, and 2^23-1 gives 6.
- R7: An address with only bits 6..0 set to a value v in 67..127 gives v-67. An address with v below 67 gives v.
- R8: An address with only bits 22..15 or only bits 14..7 non-zero gives the residue of that field's value times 2^15 or 2^7, respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe: addr is taken at this edge |
| addr | input | 23 | Unsigned binary address |
| out_valid | output | 1 | Result registered from a strobed input |
| residue | output | 7 | addr mod 67, the module number |

## Verification
The hardest case to reach is one where every partial residue is large at the same time. Both adders must then wrap, and the low field must sit above 67. Uniform random addresses hit this only rarely. The stimulus therefore adds all-ones patterns per field and field-isolated sweeps. It also sweeps all 128 low-field values, so every table entry and both subtract paths are driven. Idle cycles with a changing address show that the held result does not move.

// File: rtl/modtr_pkg.sv
package modtr_pkg;
    // Residue of (value * 2^shift) mod modulus, evaluated by repeated doubling.
    function automatic int weighted_res(int value, int shift, int modulus);
        int r;
        r = value % modulus;
        for (int s = 0; s < shift; s++) begin
            r = (r * 2) % modulus;
        end
        return r;
    endfunction
endpackage

// File: rtl/modtr_seg_lut.sv
module modtr_seg_lut #(
    parameter int SEG_W = 8,
    parameter int SHIFT = 7,
    parameter int MOD   = 67,
    parameter int RES_W = 7
) (
    input  logic [SEG_W-1:0] idx,
    output logic [RES_W-1:0] res
);
    localparam int DEPTH = 1 << SEG_W;

    logic [RES_W-1:0] table_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        assign table_q[i] = RES_W'(modtr_pkg::weighted_res(i, SHIFT, MOD));
    end

    assign res = table_q[idx];
endmodule

// File: rtl/modtr_lo_reduce.sv
module modtr_lo_reduce #(
    parameter int SEG_W = 7,
    parameter int MOD   = 67,
    parameter int RES_W = 7
) (
    input  logic [SEG_W-1:0] seg,
    output logic [RES_W-1:0] res
);
    localparam int CW = (SEG_W > RES_W) ? SEG_W : RES_W;

    logic [CW-1:0] ext;
    logic [CW-1:0] diff;

    always_comb begin
        ext  = CW'(seg);
        diff = ext - CW'(MOD);
        res  = (ext >= CW'(MOD)) ? RES_W'(diff) : RES_W'(ext);
    end
endmodule

// File: rtl/modtr_mod_add.sv
module modtr_mod_add #(
    parameter int MOD   = 67,
    parameter int RES_W = 7
) (
    input  logic [RES_W-1:0] a,
    input  logic [RES_W-1:0] b,
    output logic [RES_W-1:0] sum
);
    logic [RES_W:0] raw;
    logic [RES_W:0] wrapped;

    always_comb begin
        raw     = {1'b0, a} + {1'b0, b};
        wrapped = raw - (RES_W+1)'(MOD);
        sum     = (raw >= (RES_W+1)'(MOD)) ? RES_W'(wrapped) : RES_W'(raw);
    end
endmodule

// File: rtl/modtr_translator.sv
module modtr_translator #(
    parameter int SEG_HI_W  = 8,
    parameter int SEG_MID_W = 8,
    parameter int SEG_LO_W  = 7,
    parameter int MOD       = 67,
    parameter int RES_W     = $clog2(MOD),
    localparam int ADDR_W   = SEG_HI_W + SEG_MID_W + SEG_LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] addr,
    output logic              out_valid,
    output logic [RES_W-1:0]  residue
);
    localparam int MID_LSB = SEG_LO_W;
    localparam int HI_LSB  = SEG_LO_W + SEG_MID_W;

    typedef struct packed {
        logic             valid;
        logic [RES_W-1:0] res;
    } state_t;

    state_t st_d, st_q;

    logic [RES_W-1:0] hi_res, mid_res, lo_res, part_res, full_res;

    modtr_seg_lut #(.SEG_W(SEG_HI_W), .SHIFT(HI_LSB), .MOD(MOD), .RES_W(RES_W)) u_hi_lut (
        .idx (addr[ADDR_W-1:HI_LSB]),
        .res (hi_res)
    );

    modtr_seg_lut #(.SEG_W(SEG_MID_W), .SHIFT(MID_LSB), .MOD(MOD), .RES_W(RES_W)) u_mid_lut (
        .idx (addr[HI_LSB-1:MID_LSB]),
        .res (mid_res)
    );

    modtr_lo_reduce #(.SEG_W(SEG_LO_W), .MOD(MOD), .RES_W(RES_W)) u_lo (
        .seg (addr[SEG_LO_W-1:0]),
        .res (lo_res)
    );

    modtr_mod_add #(.MOD(MOD), .RES_W(RES_W)) u_add_upper (
        .a   (hi_res),
        .b   (mid_res),
        .sum (part_res)
    );

    modtr_mod_add #(.MOD(MOD), .RES_W(RES_W)) u_add_final (
        .a   (part_res),
        .b   (lo_res),
        .sum (full_res)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.res = full_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign residue   = st_q.res;
endmodule

// File: rtl/modtr_checker.sv
module modtr_checker #(
    parameter int ADDR_W = 23,
    parameter int MOD    = 67,
    parameter int RES_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [ADDR_W-1:0] addr,
    input logic              out_valid,
    input logic [RES_W-1:0]  residue,
    input logic [RES_W-1:0]  lo_res
);
    // R2: registered result is the true residue of the strobed address
    a_r2_residue_match: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> residue == RES_W'({9'd0, $past(addr)} % MOD));

    // R3: valid follows the strobe by one cycle
    a_r3_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r3_idle_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R4: result holds while no strobe
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(residue));

    // R5: result never reaches the modulus
    a_r5_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        residue < RES_W'(MOD));

    // R7: low-field reducer output in range and congruent to the field
    a_r7_lo_range: assert property (@(posedge clk) disable iff (!rst_n)
        lo_res < RES_W'(MOD) && (RES_W+1)'(addr[6:0]) - (RES_W+1)'(lo_res) <= (RES_W+1)'(MOD));
endmodule

bind modtr_translator modtr_checker #(.ADDR_W(ADDR_W), .MOD(MOD), .RES_W(RES_W)) u_modtr_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .addr      (addr),
    .out_valid (out_valid),
    .residue   (residue),
    .lo_res    (lo_res)
);

// File: tb/modtr_translator_bench.sv
`timescale 1ns/1ps
module modtr_translator_bench;
    localparam int ADDR_W = 23;
    localparam int MOD    = 67;
    localparam int RES_W  = 7;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              out_valid;
    logic [RES_W-1:0]  residue;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    modtr_translator u_modtr_translator (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .addr      (addr),
        .out_valid (out_valid),
        .residue   (residue)
    );

    function automatic int exp_res(logic [ADDR_W-1:0] a);
        return int'({9'd0, a} % MOD);
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Strobe one address, then sample at the following falling edge.
    task automatic apply(string req, logic [ADDR_W-1:0] a);
        @(negedge clk);
        in_valid = 1'b1;
        addr     = a;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, int'(residue), exp_res(a));
        check("R3", int'(out_valid), 1);
        check("R5", int'(residue < RES_W'(MOD)), 1);
    endtask

    // Idle cycle with a changed address: result must hold.
    task automatic idle(logic [ADDR_W-1:0] a);
        int prev;
        prev     = int'(residue);
        in_valid = 1'b0;
        addr     = a;
        @(negedge clk);
        check("R4", int'(residue), prev);
        check("R3", int'(out_valid), 0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        #3;
        check("R1", int'(out_valid), 0);
        check("R1", int'(residue), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", int'(out_valid), 0);
        check("R1", int'(residue), 0);

        // R6 corners
        apply("R6", 23'd0);
        check("R6", int'(residue), 0);
        apply("R6", 23'd66);
        check("R6", int'(residue), 66);
        apply("R6", 23'd67);
        check("R6", int'(residue), 0);
        apply("R6", 23'h7FFFFF);
        check("R6", int'(residue), 6);
        idle(23'd12345);

        // R7 low-field sweep
        for (int v = 0; v < 128; v++) begin
            apply("R7", ADDR_W'(v));
            check("R7", int'(residue), (v >= MOD) ? v - MOD : v);
        end

        // R8 isolated upper fields
        for (int v = 0; v < 256; v++) begin
            apply("R8", ADDR_W'(v) << 15);
            apply("R8", ADDR_W'(v) << 7);
        end

        // all-ones field patterns stress both adder wraps
        apply("R2", 23'h7F807F);
        apply("R2", 23'h7FFF80);
        apply("R2", 23'h007FFF);

        // R2 random with interleaved idles
        for (int n = 0; n < 2000; n++) begin
            apply("R2", ADDR_W'($urandom));
            if (($urandom % 4) == 0) idle(ADDR_W'($urandom));
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule